// File: doc/BRIEF.md
# Core Power-Down Sequencer

This block is a small bus master that shuts down one of four processor cores when asked. A request supplies a start pulse and a one-hot core selection. The sequencer first polls an idle-status register until the selected core reports that it is waiting for an interrupt. It then works through four steps: it isolates the core's outputs with a clamp, except for core 0, it puts the core into reset, it cuts every power switch of that core, and it writes its own reset register to release the shared controller.

All traffic goes through one memory-mapped read/write port with a request/ready handshake and at most one access outstanding. Each register address is a base plus an offset, and both are parameters. The clamp update and the reset update are both read-modify-write. The clamp step sets the core's bit. The reset step clears the core's bit, because a zero there means reset is asserted. The power-switch register is picked per core from the bit position of the selection.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `bus_req_o` are all low.
- R2: A start while idle is accepted when exactly one bit of `mask_i` is set. Bit n selects core n. `busy_o` is high in the following cycle, and the first access is a read of the status address (default 0x0170_0030).
- R3: The status read repeats until the returned word ANDed with the mask is non-zero. Other bits of the word are ignored. No write happens before that.
- R4: For cores 1 to 3, the next step reads the clamp register (default 0x01F0_1500) and writes it back ORed with the mask.
- R5: For core 0 the clamp step is skipped entirely. The access after the last status read is the reset-control read.
- R6: The reset-control register (default 0x01F0_1C30) is read and written back ANDed with the inverted mask.
- R7: The value 0xFF is then written to the switch register at 0x01F0_1540 + 4 × core number.
- R8: The last access writes zero to the self-reset register (default 0x01F0_1C00). `busy_o` falls at that transfer's edge, `done_o` is high for exactly one cycle, and no further request follows.
- R9: A start while idle with zero or several mask bits set causes no bus access. Instead `err_o` goes high for one cycle.
- R10: A start while busy is ignored. The running sequence and its selection are unchanged, and `err_o` stays low.
- R11: While `bus_req_o` is high and `bus_ready_i` is low, the address, write-enable and write data stay stable. Read data is used only in a cycle where `bus_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled at each edge |
| mask_i | input | NCORE | One-hot core selection |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the self-reset write |
| err_o | output | 1 | One-cycle pulse for a rejected selection |
| bus_req_o | output | 1 | Access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Access address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid with ready |
| bus_ready_i | input | 1 | Access completes at this edge |

## Verification
The hardest case to reach is a status read that returns idle bits for every core except the selected one, so that only a correct AND with the mask keeps the machine polling. It is hardest while ready is held back and garbage sits on the read-data lines, and while a second start arrives mid-sequence. The bench slave model returns the complement of the selection for a programmable number of polls and drives a junk word whenever ready is low. It stretches each access by a chosen latency, and one scenario fires a competing start during polling.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POLL,
    S_CLMP_RD,
    S_CLMP_WR,
    S_RST_RD,
    S_RST_WR,
    S_SW_WR,
    S_SELF_WR
  } seq_state_e;

  // number of set bits in a selection of up to 16 cores
  function automatic logic [4:0] count_ones16(input logic [15:0] m);
    logic [4:0] c;
    c = '0;
    for (int i = 0; i < 16; i++) c = c + 5'(m[i]);
    return c;
  endfunction

  // position of the lowest set bit (core number)
  function automatic logic [3:0] first_set16(input logic [15:0] m);
    logic [3:0] r;
    r = '0;
    for (int i = 15; i >= 0; i--) if (m[i]) r = 4'(i);
    return r;
  endfunction

  // per-core register stride of four bytes
  function automatic logic [31:0] core_stride(input logic [3:0] idx);
    return {26'd0, idx, 2'b00};
  endfunction

endpackage

// File: rtl/pwrdn_mask_dec.sv
module pwrdn_mask_dec #(
  parameter int NCORE = 4,
  parameter int IDX_W = 2
) (
  input  logic [NCORE-1:0] mask_i,
  output logic             one_hot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             core0_o
);
  logic [15:0] wide;

  always_comb begin
    wide      = 16'(mask_i);
    one_hot_o = (pwrdn_pkg::count_ones16(wide) == 5'd1);
    idx_o     = IDX_W'(pwrdn_pkg::first_set16(wide));
    core0_o   = one_hot_o && mask_i[0];
  end
endmodule

// File: rtl/pwrdn_bus_port.sv
module pwrdn_bus_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              xfer_o,
  output logic [DATA_W-1:0] rd_q_o
);
  assign xfer_o = req_i && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q_o <= '0;
    else if (xfer_o) rd_q_o <= rdata_i;
  end

  // R11: a waiting access keeps its address, direction and data
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !ready_i) |=> (req_i && $stable(addr_i) && $stable(we_i) && $stable(wdata_i)));

  // R11: captured read data changes only on a completed transfer
  a_r11_capture_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xfer_o) |-> $stable(rd_q_o));
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter int                NCORE      = 4,
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] STAT_BASE  = 'h0170_0000,
  parameter logic [ADDR_W-1:0] STAT_OFS   = 'h30,
  parameter logic [ADDR_W-1:0] CTRL_BASE  = 'h01F0_0000,
  parameter logic [ADDR_W-1:0] CLAMP_OFS  = 'h1500,
  parameter logic [ADDR_W-1:0] RST_OFS    = 'h1C30,
  parameter logic [ADDR_W-1:0] SW_OFS     = 'h1540,
  parameter logic [ADDR_W-1:0] SELF_OFS   = 'h1C00,
  parameter logic [DATA_W-1:0] SW_OFF_VAL = 'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NCORE-1:0]  mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);
  import pwrdn_pkg::*;

  localparam int IDX_W = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam logic [ADDR_W-1:0] STAT_ADDR  = STAT_BASE + STAT_OFS;
  localparam logic [ADDR_W-1:0] CLAMP_ADDR = CTRL_BASE + CLAMP_OFS;
  localparam logic [ADDR_W-1:0] RST_ADDR   = CTRL_BASE + RST_OFS;
  localparam logic [ADDR_W-1:0] SW_ADDR0   = CTRL_BASE + SW_OFS;
  localparam logic [ADDR_W-1:0] SELF_ADDR  = CTRL_BASE + SELF_OFS;

  seq_state_e        state_q, state_d;
  logic [NCORE-1:0]  mask_q;
  logic [IDX_W-1:0]  idx_q;
  logic              core0_q, done_q, err_q, done_d, err_d;
  logic              in_one_hot, in_core0;
  logic [IDX_W-1:0]  in_idx;
  logic              accept, xfer, core_idle;
  logic [DATA_W-1:0] rd_q, mask_ext;

  pwrdn_mask_dec #(.NCORE(NCORE), .IDX_W(IDX_W)) u_dec (
    .mask_i   (mask_i),
    .one_hot_o(in_one_hot),
    .idx_o    (in_idx),
    .core0_o  (in_core0)
  );

  pwrdn_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (bus_req_o),
    .we_i   (bus_we_o),
    .addr_i (bus_addr_o),
    .wdata_i(bus_wdata_o),
    .ready_i(bus_ready_i),
    .rdata_i(bus_rdata_i),
    .xfer_o (xfer),
    .rd_q_o (rd_q)
  );

  assign mask_ext  = DATA_W'(mask_q);
  assign accept    = (state_q == S_IDLE) && start_i && in_one_hot;
  assign core_idle = |(bus_rdata_i & mask_ext);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = (state_q == S_IDLE) && start_i && !in_one_hot;
    case (state_q)
      S_IDLE:    if (accept) state_d = S_POLL;
      S_POLL:    if (xfer && core_idle) state_d = core0_q ? S_RST_RD : S_CLMP_RD;
      S_CLMP_RD: if (xfer) state_d = S_CLMP_WR;
      S_CLMP_WR: if (xfer) state_d = S_RST_RD;
      S_RST_RD:  if (xfer) state_d = S_RST_WR;
      S_RST_WR:  if (xfer) state_d = S_SW_WR;
      S_SW_WR:   if (xfer) state_d = S_SELF_WR;
      S_SELF_WR: if (xfer) begin
                   state_d = S_IDLE;
                   done_d  = 1'b1;
                 end
      default:   state_d = S_IDLE;
    endcase
  end

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    case (state_q)
      S_POLL:    bus_addr_o = STAT_ADDR;
      S_CLMP_RD: bus_addr_o = CLAMP_ADDR;
      S_CLMP_WR: begin
                   bus_we_o    = 1'b1;
                   bus_addr_o  = CLAMP_ADDR;
                   bus_wdata_o = rd_q | mask_ext;
                 end
      S_RST_RD:  bus_addr_o = RST_ADDR;
      S_RST_WR:  begin
                   bus_we_o    = 1'b1;
                   bus_addr_o  = RST_ADDR;
                   bus_wdata_o = rd_q & ~mask_ext;
                 end
      S_SW_WR:   begin
                   bus_we_o    = 1'b1;
                   bus_addr_o  = SW_ADDR0 + ADDR_W'(core_stride(4'(idx_q)));
                   bus_wdata_o = SW_OFF_VAL;
                 end
      S_SELF_WR: begin
                   bus_we_o    = 1'b1;
                   bus_addr_o  = SELF_ADDR;
                 end
      default:   bus_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mask_q  <= '0;
      idx_q   <= '0;
      core0_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (accept) begin
        mask_q  <= mask_i;
        idx_q   <= in_idx;
        core0_q <= in_core0;
      end
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: an idle sequencer issues no traffic
  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_o);

  // R5: core 0 never touches the clamp register
  a_r5_core0_no_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_addr_o == CLAMP_ADDR) |-> !core0_q);

  // R3: a status reply without the selected bit keeps polling
  a_r3_keep_polling: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_POLL && xfer && !core_idle) |=> (state_q == S_POLL && !bus_we_o));

  // R9: a rejected start leaves the machine idle
  a_r9_err_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);

  // R2/R10: a running sequence always holds exactly one selected core
  a_r10_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(mask_q) == 1 && (!$past(busy_o) || $stable(mask_q))));
endmodule

// File: tb/pwrdn_seq_test.sv
`timescale 1ns/1ps
module pwrdn_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mask_i = '0;
  logic        busy_o, done_o, err_o, bus_req_o, bus_we_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_ready_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // slave model settings and log
  int          s_lat = 0, s_polls = 0, s_wait = 0, s_stat = 0;
  logic [3:0]  s_mask = '0;
  logic [31:0] s_clamp = '0, s_rst = '0;
  logic        pend = 1'b0, hold_bad = 1'b0;
  logic [31:0] p_addr, p_wdata;
  logic        p_we;
  int          log_n = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic        log_we [64];

  pwrdn_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i)
  );

  always #2.5 clk = ~clk;

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // bus slave: decides ready and read data at the falling edge
  always @(negedge clk) begin
    if (bus_req_o) begin
      if (pend && (bus_addr_o != p_addr || bus_we_o != p_we || bus_wdata_o != p_wdata))
        hold_bad = 1'b1;
      if (s_wait >= s_lat) begin
        bus_ready_i = 1'b1;
        if (bus_we_o) bus_rdata_i = 32'hDEAD_BEEF;
        else if (bus_addr_o == 32'h0170_0030) begin
          bus_rdata_i = (s_stat < s_polls) ? (32'hFFFF_FFF0 | 32'(~s_mask & 4'hF)) : 32'(s_mask);
          s_stat++;
        end
        else if (bus_addr_o == 32'h01F0_1500) bus_rdata_i = s_clamp;
        else if (bus_addr_o == 32'h01F0_1C30) bus_rdata_i = s_rst;
        else bus_rdata_i = 32'h0;
        if (log_n < 64) begin
          log_addr[log_n] = bus_addr_o;
          log_we[log_n]   = bus_we_o;
          log_data[log_n] = bus_we_o ? bus_wdata_o : bus_rdata_i;
          log_n++;
        end
        s_wait = 0; pend = 1'b0;
      end else begin
        bus_ready_i = 1'b0;
        bus_rdata_i = 32'h5A5A_A5A5;
        s_wait++; pend = 1'b1;
        p_addr = bus_addr_o; p_we = bus_we_o; p_wdata = bus_wdata_o;
      end
    end else begin
      bus_ready_i = 1'b0; bus_rdata_i = 32'h0; s_wait = 0; pend = 1'b0;
    end
  end

  task automatic t_reset;
    @(negedge clk);
    check(!busy_o && !done_o && !err_o && !bus_req_o, "R1 reset outputs",
          {28'd0, busy_o, done_o, err_o, bus_req_o}, 32'd0);
  endtask

  // one full power-down; inject fires a second start while polling
  task automatic t_seq(input int core, input int lat, input int polls,
                       input logic [31:0] clamp0, input logic [31:0] rst0, input bit inject);
    logic [3:0]  m;
    int          k, n_exp, wait_n, base_n;
    logic [31:0] ea [16];
    logic [31:0] ed [16];
    logic        ew [16];
    string       et [16];
    m = 4'(1 << core);
    s_lat = lat; s_polls = polls; s_mask = m; s_stat = 0;
    s_clamp = clamp0; s_rst = rst0; log_n = 0; hold_bad = 1'b0;
    k = 0;
    for (int i = 0; i <= polls; i++) begin
      ea[k] = 32'h0170_0030; ew[k] = 0; ed[k] = (i < polls) ? (32'hFFFF_FFF0 | 32'(~m & 4'hF)) : 32'(m);
      et[k] = "R3 status poll"; k++;
    end
    if (core != 0) begin
      ea[k] = 32'h01F0_1500; ew[k] = 0; ed[k] = clamp0; et[k] = "R4 clamp read"; k++;
      ea[k] = 32'h01F0_1500; ew[k] = 1; ed[k] = clamp0 | 32'(m); et[k] = "R4 clamp write"; k++;
    end
    ea[k] = 32'h01F0_1C30; ew[k] = 0; ed[k] = rst0;
    et[k] = (core == 0) ? "R5 core0 skips clamp" : "R6 reset read"; k++;
    ea[k] = 32'h01F0_1C30; ew[k] = 1; ed[k] = rst0 & ~32'(m); et[k] = "R6 reset write"; k++;
    ea[k] = 32'h01F0_1540 + 32'(4 * core); ew[k] = 1; ed[k] = 32'hFF; et[k] = "R7 switch write"; k++;
    ea[k] = 32'h01F0_1C00; ew[k] = 1; ed[k] = 32'h0; et[k] = "R8 self reset write"; k++;
    n_exp = k;

    @(negedge clk); start_i = 1'b1; mask_i = m;
    @(negedge clk); start_i = 1'b0; mask_i = 4'h0;
    check(busy_o && bus_req_o && !bus_we_o && bus_addr_o == 32'h0170_0030, "R2 accepted start",
          bus_addr_o, 32'h0170_0030);
    if (inject) begin
      @(negedge clk); start_i = 1'b1; mask_i = 4'b0001;
      @(negedge clk); start_i = 1'b0; mask_i = 4'h0;
      check(!err_o && busy_o, "R10 start while busy", {30'd0, err_o, busy_o}, 32'd1);
    end
    wait_n = 0;
    while (!done_o && wait_n < 3000) begin @(negedge clk); wait_n++; end
    check(done_o && !busy_o, "R8 done with busy low", {30'd0, done_o, busy_o}, 32'd2);
    base_n = log_n;
    @(negedge clk);
    check(!done_o, "R8 done one cycle", {31'd0, done_o}, 32'd0);
    repeat (5) @(negedge clk);
    check(!bus_req_o && log_n == base_n, "R8 no traffic after end", 32'(log_n), 32'(base_n));
    check(log_n == n_exp, inject ? "R10 access count" : "R3 access count", 32'(log_n), 32'(n_exp));
    for (int i = 0; i < n_exp && i < log_n; i++)
      check(log_addr[i] == ea[i] && log_we[i] == ew[i] && log_data[i] == ed[i], et[i],
            log_we[i] ? log_data[i] : log_addr[i], ew[i] ? ed[i] : ea[i]);
    check(!hold_bad, "R11 held while waiting", {31'd0, hold_bad}, 32'd0);
  endtask

  task automatic t_bad_mask(input logic [3:0] m);
    log_n = 0;
    @(negedge clk); start_i = 1'b1; mask_i = m;
    @(negedge clk); start_i = 1'b0; mask_i = 4'h0;
    check(err_o && !busy_o, "R9 error pulse", {30'd0, err_o, busy_o}, 32'd2);
    @(negedge clk);
    check(!err_o, "R9 error one cycle", {31'd0, err_o}, 32'd0);
    repeat (3) @(negedge clk);
    check(log_n == 0 && !bus_req_o, "R9 no access", 32'(log_n), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_seq(1, 0, 0, 32'h0000_0004, 32'h0000_000F, 0);
    t_seq(2, 2, 3, 32'h0000_0001, 32'hFFFF_FFFF, 0);
    t_seq(3, 1, 1, 32'h0000_0000, 32'h0000_000B, 0);
    t_seq(0, 0, 2, 32'h0000_0000, 32'h0000_000F, 0);
    t_seq(0, 3, 0, 32'h0000_0000, 32'h0000_0007, 0);
    t_bad_mask(4'h0);
    t_bad_mask(4'h3);
    t_bad_mask(4'hF);
    t_bad_mask(4'hA);
    t_seq(2, 1, 4, 32'h0000_0002, 32'h0000_000E, 1);
    report();
  end
endmodule